// File: doc/BRIEF.md
# Interrupt Presenter Register Front-End

This block is the per-thread register face of an interrupt presenter. It sits on a simple request bus that carries a 12-bit byte address inside a 4 KB window, a size of 1 to 4 bytes, a write flag and 32-bit write data. The same offset can hold two different operations. A byte access and a 32-bit access to it do different things. A 32-bit read of the acknowledge register also changes state. Every request gets a registered response one cycle later: read data, an error flag and one-cycle operation strobes.

The block holds the thread's current priority, the inter-processor interrupt (IPI) priority, three 32-bit link words and one external pending source. The pending source is loaded from a side port. From these the block forms the 32-bit interrupt word: the current priority sits in bits [31:24] and the presented source number in bits [23:0]. The block also drives an interrupt line toward the thread. Priority 0x00 is the most favoured value and 0xFF the least favoured. Byte data travels right-justified in bits [7:0] of the data buses.

Top module: `irq_presenter_regs`

## Requirements
- R1: After reset the current priority is 0x00, the IPI priority is 0xFF, all link words are zero, no source is pending and `irq` is low.
- R2: The register is selected by address bits [11:2] only. A 32-bit access ignores bits [1:0]. A byte access is legal only when bits [1:0] are zero. Sizes 2 and 3 are illegal at every offset.
- R3: A 32-bit read at offset 0x0 returns the interrupt word and changes no state. A byte read at 0x0 or 0x4 returns the current priority in bits [7:0] with zeros above. Each of these reads pulses `stb_poll`.
- R4: A 32-bit read at 0x4 returns the interrupt word as it was before the read and pulses `stb_accept`. If a source is presented, the current priority takes that source's priority and the source is withdrawn: an IPI by setting the IPI priority to 0xFF, an external source by clearing it.
- R5: A byte write at 0x4 loads bits [7:0] of the write data into the current priority and pulses `stb_cppr`.
- R6: A 32-bit write at 0x4 is an end-of-interrupt. It loads write-data bits [31:24] into the current priority, pulses `stb_eoi` and outputs bits [23:0] on `eoi_source`.
- R7: Offset 0xC holds the IPI priority. It accepts byte reads and byte writes; a write pulses `stb_ipi`. Any 32-bit access to 0xC is illegal.
- R8: Offsets 0x10, 0x14 and 0x18 are three link words. Each accepts 32-bit reads and writes only and simply stores what is written.
- R9: An illegal or unmapped access raises `rsp_err` for one response cycle and pulses no strobe. An illegal read returns 0xFFFFFFFF. An illegal write changes no state. Every other offset, including 0x8 and writes to 0x0, is unmapped.
- R10: An IPI is presented with source number 2 when its priority is lower than the current priority. An external source is presented with its own number when its priority is lower than the current priority. When both qualify, the IPI wins only if its priority is strictly lower than the external source's. When nothing qualifies, the source field is 0.
- R11: `irq` is high, one cycle after the state changes, exactly while some source qualifies under R10.
- R12: The response to a request appears in the cycle after the request. `rsp_valid` marks every read, legal or not. At most one strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data; byte writes use bits [7:0] |
| src_load | input | 1 | Load the external pending source |
| src_prio | input | 8 | Priority of the loaded source |
| src_num | input | 24 | Number of the loaded source |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 32 | Read data; byte reads in bits [7:0] |
| rsp_err | output | 1 | Previous request was illegal |
| stb_poll | output | 1 | Side-effect-free read of the interrupt word or priority |
| stb_accept | output | 1 | Acknowledge performed |
| stb_cppr | output | 1 | Current priority written by byte |
| stb_eoi | output | 1 | End-of-interrupt performed |
| stb_ipi | output | 1 | IPI priority written |
| eoi_source | output | 24 | Source number carried by the last end-of-interrupt |
| irq | output | 1 | Interrupt request to the thread |

## Verification
The assertions assume one request per cycle at most, with size, address and write flag held steady only in the cycle `bus_valid` is high. They also assume `src_load` never coincides with an acknowledge that withdraws the external source. The bench drives each request for exactly one cycle from a task and returns the bus to idle before the next. It loads the external source only while the bus is idle, so the loaded source and the acknowledge never compete.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
  typedef enum logic [3:0] {
    OP_IDLE,
    OP_BAD,
    OP_POLL_WORD,
    OP_PRIO_BYTE,
    OP_ACCEPT,
    OP_CPPR_WR,
    OP_EOI,
    OP_IPI_RD,
    OP_IPI_WR,
    OP_LINK_RD,
    OP_LINK_WR
  } ipr_op_e;

  // word offsets (address bits [11:2])
  localparam int unsigned WOFF_POLL  = 0;
  localparam int unsigned WOFF_ACK   = 1;
  localparam int unsigned WOFF_IPI   = 3;
  localparam int unsigned WOFF_LINK0 = 4;
endpackage

// File: rtl/ipr_decode.sv
module ipr_decode
  import ipr_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINK_COUNT = 3,
  parameter int LINK_IDX_W = 2
) (
  input  logic                  valid,
  input  logic                  write,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2:0]            size,
  output ipr_op_e               op,
  output logic [LINK_IDX_W-1:0] link_idx
);
  localparam int OFF_W = ADDR_W - 2;
  localparam logic [OFF_W-1:0] O_POLL  = OFF_W'(WOFF_POLL);
  localparam logic [OFF_W-1:0] O_ACK   = OFF_W'(WOFF_ACK);
  localparam logic [OFF_W-1:0] O_IPI   = OFF_W'(WOFF_IPI);
  localparam logic [OFF_W-1:0] O_LINK0 = OFF_W'(WOFF_LINK0);
  localparam logic [OFF_W-1:0] O_LEND  = OFF_W'(WOFF_LINK0 + LINK_COUNT);

  logic [OFF_W-1:0] off;
  logic             is_word;
  logic             is_byte0;
  logic [OFF_W-1:0] link_off;

  assign off      = addr[ADDR_W-1:2];
  assign is_word  = (size == 3'd4);
  assign is_byte0 = (size == 3'd1) && (addr[1:0] == 2'b00);
  assign link_off = off - O_LINK0;

  always_comb begin
    op       = OP_IDLE;
    link_idx = '0;
    if (valid) begin
      op = OP_BAD;
      if (off == O_POLL) begin
        if (!write && is_word)       op = OP_POLL_WORD;
        else if (!write && is_byte0) op = OP_PRIO_BYTE;
      end else if (off == O_ACK) begin
        if (is_word)       op = write ? OP_EOI : OP_ACCEPT;
        else if (is_byte0) op = write ? OP_CPPR_WR : OP_PRIO_BYTE;
      end else if (off == O_IPI) begin
        if (is_byte0) op = write ? OP_IPI_WR : OP_IPI_RD;
      end else if (off >= O_LINK0 && off < O_LEND) begin
        link_idx = LINK_IDX_W'(link_off);
        if (is_word) op = write ? OP_LINK_WR : OP_LINK_RD;
      end
    end
  end
endmodule

// File: rtl/ipr_prio_core.sv
module ipr_prio_core #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_en,
  input  logic                  cppr_wr,
  input  logic [PRIO_W-1:0]     cppr_val,
  input  logic                  ipi_wr,
  input  logic [PRIO_W-1:0]     ipi_val,
  input  logic                  src_load,
  input  logic [PRIO_W-1:0]     src_prio,
  input  logic [SRC_W-1:0]      src_num,
  output logic [PRIO_W-1:0]     cppr,
  output logic [PRIO_W-1:0]     ipi_prio,
  output logic [PRIO_W+SRC_W-1:0] word,
  output logic                  hit
);
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  logic              ext_v;
  logic [PRIO_W-1:0] ext_p;
  logic [SRC_W-1:0]  ext_n;
  logic              ext_ok, ipi_ok, pick_ipi;
  logic [SRC_W-1:0]  sel_src;
  logic [PRIO_W-1:0] sel_prio;

  always_comb begin
    ext_ok   = ext_v && (ext_p < cppr);
    ipi_ok   = ipi_prio < cppr;
    pick_ipi = ipi_ok && (!ext_ok || (ipi_prio < ext_p));
    sel_src  = pick_ipi ? IPI_NUM : (ext_ok ? ext_n : '0);
    sel_prio = pick_ipi ? ipi_prio : ext_p;
    hit      = ext_ok || ipi_ok;
    word     = {cppr, sel_src};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cppr     <= '0;
      ipi_prio <= '1;
      ext_v    <= 1'b0;
      ext_p    <= '1;
      ext_n    <= '0;
    end else begin
      if (cppr_wr) cppr     <= cppr_val;
      if (ipi_wr)  ipi_prio <= ipi_val;
      if (acc_en && hit) begin
        cppr <= sel_prio;
        if (pick_ipi) ipi_prio <= '1;
        else          ext_v    <= 1'b0;
      end
      if (src_load) begin
        ext_v <= 1'b1;
        ext_p <= src_prio;
        ext_n <= src_num;
      end
    end
  end
endmodule

// File: rtl/ipr_link_bank.sv
module ipr_link_bank #(
  parameter int DATA_W     = 32,
  parameter int LINK_COUNT = 3,
  parameter int IDX_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] link_q [LINK_COUNT];

  for (genvar g = 0; g < LINK_COUNT; g++) begin : g_link
    always_ff @(posedge clk) begin
      if (rst)                                  link_q[g] <= '0;
      else if (wr_en && idx == IDX_W'(g))       link_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < LINK_COUNT; i++)
      if (idx == IDX_W'(i)) rdata = link_q[i];
  end
endmodule

// File: rtl/irq_presenter_regs.sv
module irq_presenter_regs
  import ipr_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PRIO_W     = 8,
  parameter int SRC_W      = 24,
  parameter int LINK_COUNT = 3,
  parameter int IPI_SRC    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [2:0]                bus_size,
  input  logic [PRIO_W+SRC_W-1:0]   bus_wdata,
  input  logic                      src_load,
  input  logic [PRIO_W-1:0]         src_prio,
  input  logic [SRC_W-1:0]          src_num,
  output logic                      rsp_valid,
  output logic [PRIO_W+SRC_W-1:0]   rsp_data,
  output logic                      rsp_err,
  output logic                      stb_poll,
  output logic                      stb_accept,
  output logic                      stb_cppr,
  output logic                      stb_eoi,
  output logic                      stb_ipi,
  output logic [SRC_W-1:0]          eoi_source,
  output logic                      irq
);
  localparam int DATA_W = PRIO_W + SRC_W;
  localparam int IDX_W  = (LINK_COUNT > 1) ? $clog2(LINK_COUNT) : 1;

  ipr_op_e           op;
  logic [IDX_W-1:0]  link_idx;
  logic [PRIO_W-1:0] cppr, ipi_prio;
  logic [DATA_W-1:0] word, link_rd, rd_next;
  logic              hit, cppr_wr;
  logic [PRIO_W-1:0] cppr_val;

  ipr_decode #(.ADDR_W(ADDR_W), .LINK_COUNT(LINK_COUNT), .LINK_IDX_W(IDX_W)) u_dec (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr), .size(bus_size),
    .op(op), .link_idx(link_idx)
  );

  assign cppr_wr  = (op == OP_CPPR_WR) || (op == OP_EOI);
  assign cppr_val = (op == OP_EOI) ? bus_wdata[DATA_W-1:SRC_W] : bus_wdata[PRIO_W-1:0];

  ipr_prio_core #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_core (
    .clk(clk), .rst(rst),
    .acc_en(op == OP_ACCEPT),
    .cppr_wr(cppr_wr), .cppr_val(cppr_val),
    .ipi_wr(op == OP_IPI_WR), .ipi_val(bus_wdata[PRIO_W-1:0]),
    .src_load(src_load), .src_prio(src_prio), .src_num(src_num),
    .cppr(cppr), .ipi_prio(ipi_prio), .word(word), .hit(hit)
  );

  ipr_link_bank #(.DATA_W(DATA_W), .LINK_COUNT(LINK_COUNT), .IDX_W(IDX_W)) u_links (
    .clk(clk), .rst(rst),
    .wr_en(op == OP_LINK_WR), .idx(link_idx),
    .wdata(bus_wdata), .rdata(link_rd)
  );

  always_comb begin
    unique case (op)
      OP_POLL_WORD, OP_ACCEPT: rd_next = word;
      OP_PRIO_BYTE:            rd_next = DATA_W'(cppr);
      OP_IPI_RD:               rd_next = DATA_W'(ipi_prio);
      OP_LINK_RD:              rd_next = link_rd;
      default:                 rd_next = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_err    <= 1'b0;
      stb_poll   <= 1'b0;
      stb_accept <= 1'b0;
      stb_cppr   <= 1'b0;
      stb_eoi    <= 1'b0;
      stb_ipi    <= 1'b0;
      eoi_source <= '0;
      irq        <= 1'b0;
    end else begin
      rsp_valid  <= bus_valid && !bus_write;
      rsp_data   <= (bus_valid && !bus_write) ? rd_next : '0;
      rsp_err    <= (op == OP_BAD);
      stb_poll   <= (op == OP_POLL_WORD) || (op == OP_PRIO_BYTE);
      stb_accept <= (op == OP_ACCEPT);
      stb_cppr   <= (op == OP_CPPR_WR);
      stb_eoi    <= (op == OP_EOI);
      stb_ipi    <= (op == OP_IPI_WR);
      if (op == OP_EOI) eoi_source <= bus_wdata[SRC_W-1:0];
      irq        <= hit;
    end
  end
endmodule

// File: rtl/ipr_checker.sv
module ipr_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_err,
  input logic              stb_poll,
  input logic              stb_accept,
  input logic              stb_cppr,
  input logic              stb_eoi,
  input logic              stb_ipi
);
  // R12
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(bus_valid && !bus_write));

  // R12
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb_poll, stb_accept, stb_cppr, stb_eoi, stb_ipi}));

  // R9
  bad_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_err && rsp_valid) |-> (rsp_data == '1));

  // R9
  err_from_request_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(bus_valid));

  // R9
  err_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> !(stb_poll || stb_accept || stb_cppr || stb_eoi || stb_ipi));

  // R4
  accept_is_read_chk: assert property (@(posedge clk) disable iff (rst)
    stb_accept |-> (rsp_valid && !rsp_err));

  // R6
  eoi_is_write_chk: assert property (@(posedge clk) disable iff (rst)
    stb_eoi |-> (!rsp_valid && $past(bus_write)));
endmodule

bind irq_presenter_regs ipr_checker #(.DATA_W(PRIO_W + SRC_W)) u_ipr_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
  .stb_poll(stb_poll), .stb_accept(stb_accept), .stb_cppr(stb_cppr),
  .stb_eoi(stb_eoi), .stb_ipi(stb_ipi)
);

// File: tb/irq_presenter_regs_bench.sv
module irq_presenter_regs_bench;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [2:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic        src_load = 1'b0;
  logic [7:0]  src_prio = '0;
  logic [23:0] src_num = '0;
  logic        rsp_valid, rsp_err, stb_poll, stb_accept, stb_cppr, stb_eoi, stb_ipi, irq;
  logic [31:0] rsp_data;
  logic [23:0] eoi_source;

  int checks = 0, fails = 0;
  logic [31:0] r_data;
  logic        r_err, r_valid;
  logic [4:0]  r_stb;

  always #(CLK_P/2) clk = ~clk;

  irq_presenter_regs u_irq_presenter_regs (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .src_load(src_load), .src_prio(src_prio), .src_num(src_num),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .stb_poll(stb_poll), .stb_accept(stb_accept), .stb_cppr(stb_cppr),
    .stb_eoi(stb_eoi), .stb_ipi(stb_ipi), .eoi_source(eoi_source), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request; response captured at the next falling edge
  task automatic access(input logic wr, input logic [11:0] a, input logic [2:0] sz,
                        input logic [31:0] wd);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    @(negedge clk);
    r_data = rsp_data; r_err = rsp_err; r_valid = rsp_valid;
    r_stb  = {stb_poll, stb_accept, stb_cppr, stb_eoi, stb_ipi};
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
  endtask

  task automatic irq_is(input string tag, input logic exp);
    @(negedge clk);
    @(negedge clk);
    check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic load_src(input logic [7:0] p, input logic [23:0] n);
    @(negedge clk);
    src_load = 1'b1; src_prio = p; src_num = n;
    @(negedge clk);
    src_load = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 irq low", {31'b0, irq}, 32'h0);
    access(0, 12'h000, 4, 0); check("R1 poll word", r_data, 32'h0000_0000);
    access(0, 12'h00C, 1, 0); check("R1 ipi prio", r_data, 32'h0000_00FF);
    access(0, 12'h014, 4, 0); check("R1 link", r_data, 32'h0);
  endtask

  task automatic t_links;
    access(1, 12'h010, 4, 32'hA5A5_0001);
    access(1, 12'h014, 4, 32'h1234_5678);
    access(1, 12'h018, 4, 32'hDEAD_BEEF);
    access(0, 12'h010, 4, 0); check("R8 link0", r_data, 32'hA5A5_0001);
    access(0, 12'h018, 4, 0); check("R8 link2", r_data, 32'hDEAD_BEEF);
    access(1, 12'h010, 1, 32'h77);  check("R8 byte write err", {31'b0, r_err}, 1);
    access(0, 12'h010, 4, 0); check("R8 link0 kept", r_data, 32'hA5A5_0001);
    access(0, 12'h016, 4, 0); check("R2 alias low bits", r_data, 32'h1234_5678);
    check("R9 err one cycle", {31'b0, r_err}, 0);
  endtask

  task automatic t_cppr;
    access(1, 12'h004, 1, 32'h0000_00FF);
    check("R5 cppr strobe", {27'b0, r_stb}, 32'b00100);
    access(0, 12'h000, 1, 0); check("R3 byte poll", r_data, 32'h0000_00FF);
    check("R3 poll strobe", {27'b0, r_stb}, 32'b10000);
    access(0, 12'h004, 1, 0); check("R3 byte at ack", r_data, 32'h0000_00FF);
    access(0, 12'h000, 4, 0); check("R3 word unchanged", r_data, 32'hFF00_0000);
  endtask

  task automatic t_ipi;
    access(1, 12'h00C, 1, 32'h05); check("R7 ipi strobe", {27'b0, r_stb}, 32'b00001);
    irq_is("R11 ipi irq", 1);
    access(0, 12'h000, 4, 0); check("R10 ipi presented", r_data, 32'hFF00_0002);
    access(0, 12'h000, 4, 0); check("R3 poll no effect", r_data, 32'hFF00_0002);
    access(0, 12'h004, 4, 0); check("R4 accept word", r_data, 32'hFF00_0002);
    check("R4 accept strobe", {27'b0, r_stb}, 32'b01000);
    access(0, 12'h000, 4, 0); check("R4 cppr taken", r_data, 32'h0500_0000);
    access(0, 12'h00C, 1, 0); check("R4 ipi withdrawn", r_data, 32'h0000_00FF);
    irq_is("R11 irq cleared", 0);
  endtask

  task automatic t_external;
    access(1, 12'h004, 1, 32'hFF);
    access(1, 12'h00C, 1, 32'h20);
    load_src(8'h10, 24'h12_3456);
    access(0, 12'h000, 4, 0); check("R10 ext beats ipi", r_data, 32'hFF12_3456);
    access(0, 12'h004, 4, 0); check("R4 accept ext", r_data, 32'hFF12_3456);
    access(0, 12'h000, 4, 0); check("R10 nothing qualifies", r_data, 32'h1000_0000);
    irq_is("R11 no irq", 0);
    access(1, 12'h004, 4, 32'hFF65_4321);
    check("R6 eoi strobe", {27'b0, r_stb}, 32'b00010);
    check("R6 eoi source", {8'b0, eoi_source}, 32'h0065_4321);
    access(0, 12'h000, 4, 0); check("R6 cppr from eoi", r_data, 32'hFF00_0002);
    irq_is("R11 ipi after eoi", 1);
    load_src(8'h20, 24'h00_0077);
    access(0, 12'h000, 4, 0); check("R10 tie goes external", r_data, 32'hFF00_0077);
    access(0, 12'h004, 4, 0);
    access(0, 12'h000, 4, 0); check("R4 then ipi blocked", r_data, 32'h2000_0000);
    access(1, 12'h004, 1, 32'hFF);
    access(0, 12'h004, 4, 0); check("R4 accept ipi", r_data, 32'hFF00_0002);
  endtask

  task automatic t_illegal;
    access(0, 12'h000, 2, 0); check("R2 size2 read", r_data, 32'hFFFF_FFFF);
    check("R9 err flag", {31'b0, r_err}, 1);
    access(0, 12'h001, 1, 0); check("R2 odd byte read", {r_err, r_data[30:0]}, 32'hFFFF_FFFF);
    access(0, 12'h00C, 4, 0); check("R7 word ipi read", r_data, 32'hFFFF_FFFF);
    access(0, 12'h008, 4, 0); check("R9 hole 0x8", r_data, 32'hFFFF_FFFF);
    access(0, 12'h800, 4, 0); check("R9 high offset", {31'b0, r_err}, 1);
    access(1, 12'h00D, 1, 32'h11); check("R9 bad write strobes", {27'b0, r_stb}, 0);
    access(1, 12'h00C, 4, 32'h11); check("R7 word write err", {31'b0, r_err}, 1);
    access(1, 12'h000, 4, 32'h0);  check("R9 write to poll err", {31'b0, r_err}, 1);
    access(0, 12'h00C, 1, 0); check("R9 ipi untouched", r_data, 32'h0000_00FF);
    access(0, 12'h000, 4, 0); check("R9 cppr untouched", r_data, 32'h2000_0000);
    check("R12 read valid", {31'b0, r_valid}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_links();
    t_cppr();
    t_ipi();
    t_external();
    t_illegal();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule